// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 19-bit virtual page number into a 15-bit physical frame number. It does so by reading two 32-bit entries from a page table held in memory. A request arrives when the translation buffer misses. It carries the page number, the physical base of the root table, the kind of access (load, store or instruction fetch) and whether the access comes from user mode. The walker first reads the root entry, which is selected by the top 8 page-number bits. If that entry is usable, it then reads the leaf entry, which is selected by the low 11 bits inside the second-level table that the root entry points to. It checks the leaf against the access and returns the frame, the five flag bits of the last entry it read, a fault code, and the level at which the walk ended.

Every entry uses the same format. The frame is in bits [19:5]. The flags are: kernel-only in bit 4, executable in bit 3, writeable in bit 2, readable in bit 1 and valid in bit 0. Bits [31:20] are reserved and must be zero. Only one walk is in flight at a time.

All three data interfaces use valid/ready:
- **Request port.** A request is taken on a cycle where `req_valid` and `req_ready` are both high.
- **Memory port.** The walker holds its read address stable until the memory accepts it. It then waits for the read data, with `mem_rsp_ready` high.
- **Response port.** The result stays stable until the consumer raises `rsp_ready`. While the response is held, the walker takes no new request. Back-pressure therefore reaches the request port.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high exactly when the walker is idle, which includes during reset. `busy` rises on the cycle after a request is accepted. It stays high through the response handshake and is low on the cycle after that handshake.
- R2: The first memory read is issued to `req_root + 4 * vpn[18:11]`.
- R3: When the first entry is valid with zero reserved bits, a second read is issued to `{entry1[19:5], 13'b0} + 4 * vpn[10:0]`.
- R4: A walk that succeeds returns fault code 0, level 1, `rsp_pfn = entry2[19:5]` and `rsp_flags = entry2[4:0]`.
- R5: A clear valid bit (bit 0) ends the walk with fault code 1. `rsp_level` is 0 for the first level and 1 for the second. A walk that stops at the first level issues exactly one memory read.
- R6: A non-zero reserved field (bits [31:20]) at either level ends the walk with fault code 3. This takes priority over the valid check.
- R7: Only the leaf is checked for permission, with `req_access` encoded as 0 = load, 1 = store, 2 = fetch, 3 = undefined.
  - A load needs readable (bit 1), a store needs writeable (bit 2) and a fetch needs executable (bit 3). Code 3 always faults.
  - A user access (`req_user` = 1) to a kernel-only leaf (bit 4) faults.
  - Any of these failures gives fault code 2. The permission bits of a first-level entry are never checked.
- R8: A memory request is held with a stable address until `mem_req_ready`. Only one read is outstanding at a time.
- R9: While `rsp_ready` is low, `rsp_valid` and all response fields stay stable. On a fault, `rsp_pfn` and `rsp_flags` carry the fields of the entry at which the walk stopped.
- R10: A request presented while busy is not accepted. It starts no memory read and does not change the result of the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request taken this cycle if valid |
| req_vpn | input | 19 | Virtual page number (VA[31:13]) |
| req_root | input | 28 | Physical byte address of the root table |
| req_access | input | 2 | 0 load, 1 store, 2 fetch, 3 undefined |
| req_user | input | 1 | Access issued from user mode |
| busy | output | 1 | Walk in progress or result pending |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 28 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_ready | output | 1 | Walker waiting for read data |
| mem_rsp_data | input | 32 | Entry word |
| rsp_valid | output | 1 | Walk result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_pfn | output | 15 | Frame field of the last entry read |
| rsp_flags | output | 5 | Flag field of the last entry read |
| rsp_fault | output | 2 | 0 none, 1 invalid, 2 permission, 3 reserved bits set |
| rsp_level | output | 1 | Level where the walk ended (0 first, 1 second) |

## Verification
The main function is driven from a vector table with a range of page numbers, including all ones and all zeros, so that both index fields are tested at their extremes in the two computed addresses.

- **Clean walks.** These use each access kind with matching flag bits. They separate a correct frame/flag extraction from shifted or swapped fields.
- **Stops at each level.** One entry at a time is made invalid or given reserved bits, or both. This shows whether the level is reported correctly, whether the second read is skipped, and the reserved-over-valid priority.
- **Permission patterns.** Leaves lacking only the needed bit, and kernel-only leaves under user and kernel mode, separate each permission rule from the others.
- **Timing variations.** Memory stalls, held responses and requests raised mid-walk check the handshake rules.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  localparam int DEF_VA_W      = 32;
  localparam int DEF_PA_W      = 28;
  localparam int DEF_PAGE_BITS = 13;
  localparam int DEF_L1_IDX_W  = 8;
  localparam int DEF_PTE_W     = 32;

  localparam int FLAG_W = 5;
  localparam int FB_V   = 0;
  localparam int FB_R   = 1;
  localparam int FB_W   = 2;
  localparam int FB_X   = 3;
  localparam int FB_K   = 4;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_PERM    = 2'd2,
    FLT_RSVD    = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_UNDEF = 2'd3
  } access_e;

endpackage

// File: rtl/xlate_addr_gen.sv
module xlate_addr_gen #(
  parameter int PA_W      = xlate_pkg::DEF_PA_W,
  parameter int PAGE_BITS = xlate_pkg::DEF_PAGE_BITS,
  parameter int VPN_W     = xlate_pkg::DEF_VA_W - xlate_pkg::DEF_PAGE_BITS,
  parameter int L1_IDX_W  = xlate_pkg::DEF_L1_IDX_W,
  parameter int PTE_LG    = 2
) (
  input  logic [PA_W-1:0]           root_base,
  input  logic [VPN_W-1:0]          vpn,
  input  logic [PA_W-PAGE_BITS-1:0] l2_frame,
  input  logic                      second,
  output logic [PA_W-1:0]           addr
);
  localparam int PFN_W    = PA_W - PAGE_BITS;
  localparam int L2_IDX_W = VPN_W - L1_IDX_W;

  logic [PA_W-1:0] l1_off;
  logic [PA_W-1:0] l2_off;
  logic [PA_W-1:0] l2_base;

  // Entry offsets: index scaled by the entry size in bytes.
  assign l1_off  = {{(PA_W-L1_IDX_W-PTE_LG){1'b0}}, vpn[VPN_W-1 -: L1_IDX_W], {PTE_LG{1'b0}}};
  assign l2_off  = {{(PA_W-L2_IDX_W-PTE_LG){1'b0}}, vpn[L2_IDX_W-1:0], {PTE_LG{1'b0}}};
  assign l2_base = {l2_frame[PFN_W-1:0], {PAGE_BITS{1'b0}}};

  assign addr = second ? (l2_base + l2_off) : (root_base + l1_off);

endmodule

// File: rtl/xlate_entry_check.sv
module xlate_entry_check
  import xlate_pkg::*;
#(
  parameter int PTE_W = DEF_PTE_W,
  parameter int PFN_W = DEF_PA_W - DEF_PAGE_BITS
) (
  input  logic [PTE_W-1:0]  entry,
  input  logic              leaf,
  input  logic [1:0]        access,
  input  logic              user,
  output logic [1:0]        fault,
  output logic [PFN_W-1:0]  pfn,
  output logic [FLAG_W-1:0] flags
);
  localparam int RSV_LSB = FLAG_W + PFN_W;

  logic rsvd_set;
  logic perm_ok;

  assign flags    = entry[FLAG_W-1:0];
  assign pfn      = entry[RSV_LSB-1:FLAG_W];
  assign rsvd_set = |entry[PTE_W-1:RSV_LSB];

  always_comb begin
    case (access_e'(access))
      ACC_LOAD:  perm_ok = flags[FB_R];
      ACC_STORE: perm_ok = flags[FB_W];
      ACC_FETCH: perm_ok = flags[FB_X];
      default:   perm_ok = 1'b0;
    endcase
    if (user && flags[FB_K]) perm_ok = 1'b0;
  end

  // Priority: reserved field, then valid bit, then leaf permissions.
  always_comb begin
    if (rsvd_set)               fault = FLT_RSVD;
    else if (!flags[FB_V])      fault = FLT_INVALID;
    else if (leaf && !perm_ok)  fault = FLT_PERM;
    else                        fault = FLT_NONE;
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import xlate_pkg::*;
#(
  parameter int VA_W      = DEF_VA_W,
  parameter int PA_W      = DEF_PA_W,
  parameter int PAGE_BITS = DEF_PAGE_BITS,
  parameter int L1_IDX_W  = DEF_L1_IDX_W,
  parameter int PTE_W     = DEF_PTE_W,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PFN_W    = PA_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [PA_W-1:0]   req_root,
  input  logic [1:0]        req_access,
  input  logic              req_user,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic [FLAG_W-1:0] rsp_flags,
  output logic [1:0]        rsp_fault,
  output logic              rsp_level
);

  typedef enum logic [2:0] {
    S_IDLE, S_REQ1, S_WAIT1, S_REQ2, S_WAIT2, S_RESP
  } state_e;

  state_e             state;
  logic [VPN_W-1:0]   vpn_q;
  logic [PA_W-1:0]    root_q;
  logic [1:0]         acc_q;
  logic               user_q;
  logic [PFN_W-1:0]   pfn_q;
  logic [FLAG_W-1:0]  flags_q;
  logic [1:0]         fault_q;
  logic               level_q;

  logic [1:0]         chk_fault;
  logic [PFN_W-1:0]   chk_pfn;
  logic [FLAG_W-1:0]  chk_flags;

  assign req_ready     = (state == S_IDLE);
  assign busy          = (state != S_IDLE);
  assign mem_req_valid = (state == S_REQ1) || (state == S_REQ2);
  assign mem_rsp_ready = (state == S_WAIT1) || (state == S_WAIT2);
  assign rsp_valid     = (state == S_RESP);
  assign rsp_pfn       = pfn_q;
  assign rsp_flags     = flags_q;
  assign rsp_fault     = fault_q;
  assign rsp_level     = level_q;

  xlate_addr_gen #(
    .PA_W      (PA_W),
    .PAGE_BITS (PAGE_BITS),
    .VPN_W     (VPN_W),
    .L1_IDX_W  (L1_IDX_W),
    .PTE_LG    (2)
  ) u_addr (
    .root_base (root_q),
    .vpn       (vpn_q),
    .l2_frame  (pfn_q),
    .second    (state == S_REQ2),
    .addr      (mem_req_addr)
  );

  xlate_entry_check #(
    .PTE_W (PTE_W),
    .PFN_W (PFN_W)
  ) u_check (
    .entry  (mem_rsp_data),
    .leaf   (state == S_WAIT2),
    .access (acc_q),
    .user   (user_q),
    .fault  (chk_fault),
    .pfn    (chk_pfn),
    .flags  (chk_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      vpn_q   <= '0;
      root_q  <= '0;
      acc_q   <= '0;
      user_q  <= 1'b0;
      pfn_q   <= '0;
      flags_q <= '0;
      fault_q <= '0;
      level_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          vpn_q  <= req_vpn;
          root_q <= req_root;
          acc_q  <= req_access;
          user_q <= req_user;
          state  <= S_REQ1;
        end
        S_REQ1: if (mem_req_ready) state <= S_WAIT1;
        S_WAIT1: if (mem_rsp_valid) begin
          // pfn_q doubles as the second-level table frame on success.
          pfn_q   <= chk_pfn;
          flags_q <= chk_flags;
          fault_q <= chk_fault;
          level_q <= 1'b0;
          state   <= (chk_fault == FLT_NONE) ? S_REQ2 : S_RESP;
        end
        S_REQ2: if (mem_req_ready) state <= S_WAIT2;
        S_WAIT2: if (mem_rsp_valid) begin
          pfn_q   <= chk_pfn;
          flags_q <= chk_flags;
          fault_q <= chk_fault;
          level_q <= 1'b1;
          state   <= S_RESP;
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R8

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pfn) && $stable(rsp_flags)
      && $stable(rsp_fault) && $stable(rsp_level)); // R9

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !rsp_valid && !req_ready); // R1

  AST_OK_IS_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault == FLT_NONE) |-> rsp_level && rsp_flags[FB_V]); // R4

  AST_L1_STOP_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_level |-> rsp_fault != FLT_NONE); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !mem_rsp_ready && !rsp_valid); // R10

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  import xlate_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [27:0] ROOT = 28'h0F00000;

  typedef struct packed {
    logic [18:0] vpn;
    logic [1:0]  acc;
    logic        usr;
    logic [31:0] e1;
    logic [31:0] e2;
    logic [1:0]  xf;
    logic        xl;
    logic [14:0] xpfn;
    logic [4:0]  xflg;
    logic [1:0]  nrd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{19'h12345, 2'd0, 1'b0, 32'h00000801, 32'h00035783, 2'd0, 1'b1, 15'h1ABC, 5'h03, 2'd2},
    '{19'h7FFFF, 2'd1, 1'b1, 32'h000FFFE1, 32'h00000027, 2'd0, 1'b1, 15'h0001, 5'h07, 2'd2},
    '{19'h00000, 2'd2, 1'b1, 32'h00002461, 32'h00086429, 2'd0, 1'b1, 15'h4321, 5'h09, 2'd2},
    '{19'h0ABCD, 2'd0, 1'b0, 32'h00000800, 32'h00000000, 2'd1, 1'b0, 15'h0040, 5'h00, 2'd1},
    '{19'h3C0F0, 2'd0, 1'b0, 32'h00000801, 32'h00044442, 2'd1, 1'b1, 15'h2222, 5'h02, 2'd2},
    '{19'h01111, 2'd0, 1'b0, 32'h80000801, 32'h00000000, 2'd3, 1'b0, 15'h0040, 5'h01, 2'd1},
    '{19'h22222, 2'd0, 1'b0, 32'h00000801, 32'h001000A2, 2'd3, 1'b1, 15'h0005, 5'h02, 2'd2},
    '{19'h33333, 2'd1, 1'b0, 32'h00000801, 32'h00002003, 2'd2, 1'b1, 15'h0100, 5'h03, 2'd2},
    '{19'h44444, 2'd0, 1'b1, 32'h00000801, 32'h00002033, 2'd2, 1'b1, 15'h0101, 5'h13, 2'd2},
    '{19'h55555, 2'd0, 1'b0, 32'h00000801, 32'h00002033, 2'd0, 1'b1, 15'h0101, 5'h13, 2'd2},
    '{19'h66666, 2'd3, 1'b0, 32'h00000801, 32'h0001578F, 2'd2, 1'b1, 15'h0ABC, 5'h0F, 2'd2},
    '{19'h11111, 2'd2, 1'b0, 32'h00000801, 32'h00006667, 2'd2, 1'b1, 15'h0333, 5'h07, 2'd2}
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [18:0] req_vpn;
  logic [27:0] req_root;
  logic [1:0]  req_access;
  logic        req_user;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [27:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [14:0] rsp_pfn;
  logic [4:0]  rsp_flags;
  logic [1:0]  rsp_fault;
  logic        rsp_level;

  pt_walker u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_vpn, .req_root, .req_access, .req_user,
    .busy, .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_rsp_valid, .mem_rsp_ready,
    .mem_rsp_data, .rsp_valid, .rsp_ready, .rsp_pfn, .rsp_flags, .rsp_fault, .rsp_level
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory model: one-cycle read latency, optional request stalls.
  logic [31:0] pmem [logic [27:0]];
  logic [27:0] addr_log [256];
  int          n_rd = 0;
  int          cyc  = 0;
  logic        stall = 1'b0;
  int          checks = 0;
  int          fails  = 0;

  assign mem_req_ready = !stall || cyc[0];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
    end else begin
      if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= pmem.exists(mem_req_addr) ? pmem[mem_req_addr] : 32'h0;
        addr_log[n_rd & 255] <= mem_req_addr;
        n_rd <= n_rd + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc >= WATCHDOG) begin
      fails++;
      $display("FAIL R1 watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string fault_tag(input logic [1:0] f);
    case (f)
      2'd0:    return "R4";
      2'd1:    return "R5";
      2'd2:    return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic run_vec(input vec_t v, input int hold, input bit poke, input bit stall_on);
    logic [27:0] a1;
    logic [27:0] a2;
    int          base;
    int          t;
    logic [14:0] c_pfn;
    logic [4:0]  c_flg;
    logic [1:0]  c_flt;
    logic        c_lvl;
    string       tg;
    pmem.delete();
    a1 = ROOT + {18'b0, v.vpn[18:11], 2'b00};
    a2 = {v.e1[19:5], 13'b0} + {15'b0, v.vpn[10:0], 2'b00};
    pmem[a1] = v.e1;
    pmem[a2] = v.e2;
    tg = fault_tag(v.xf);
    @(negedge clk);
    stall      = stall_on;
    base       = n_rd;
    req_valid  = 1'b1;
    req_vpn    = v.vpn;
    req_root   = ROOT;
    req_access = v.acc;
    req_user   = v.usr;
    t = 0;
    while (!req_ready && t < 100) begin @(negedge clk); t++; end
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      req_valid = 1'b1;
      req_vpn   = ~v.vpn;
      chk("R10", "req_ready while busy", req_ready, 0);
      chk("R1", "busy during walk", busy, 1);
      @(negedge clk);
      chk("R10", "req_ready while busy again", req_ready, 0);
      @(negedge clk);
      req_valid = 1'b0;
    end
    t = 0;
    while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
    chk("R1", "response reached", rsp_valid, 1);
    c_pfn = rsp_pfn; c_flg = rsp_flags; c_flt = rsp_fault; c_lvl = rsp_level;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R9", "rsp_valid held", rsp_valid, 1);
      chk("R9", "pfn held", rsp_pfn, c_pfn);
      chk("R9", "fault held", {rsp_fault, rsp_level, rsp_flags}, {c_flt, c_lvl, c_flg});
    end
    chk("R1", "busy before handshake", busy, 1);
    chk(tg, "fault code", c_flt, v.xf);
    chk(tg, "level", c_lvl, v.xl);
    chk(tg, "pfn", c_pfn, v.xpfn);
    chk(tg, "flags", c_flg, v.xflg);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R1", "busy after handshake", busy, 0);
    chk("R9", "rsp_valid after handshake", rsp_valid, 0);
    chk((v.nrd == 2'd1) ? "R5" : "R3", "read count", n_rd - base, v.nrd);
    chk("R2", "first read address", addr_log[base & 255], a1);
    if (v.nrd == 2'd2) chk("R3", "second read address", addr_log[(base + 1) & 255], a2);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk("R10", "no reads after ignored request", n_rd - base, v.nrd);
      chk("R10", "no second result", rsp_valid, 0);
    end
  endtask

  initial begin
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_vpn    = '0;
    req_root   = '0;
    req_access = '0;
    req_user   = 1'b0;
    rsp_ready  = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "reset req_ready", req_ready, 1);
    chk("R1", "reset busy", busy, 0);
    chk("R9", "reset rsp_valid", rsp_valid, 0);
    chk("R8", "reset mem_req_valid", mem_req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i % 3, 1'b0, i[0]);

    // R10: request raised mid-walk must be ignored.
    run_vec(VECS[0], 1, 1'b1, 1'b1);
    // R9 / R8: long response hold under memory stalls.
    run_vec(VECS[1], 5, 1'b0, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule